// File: doc/BRIEF.md
# Half-Pel Motion Compensation Predictor

This block forms an 8x8 block of predicted pixels from a reference picture kept in a memory of 32-bit words. A single start pulse supplies the source byte address, source row stride, destination byte address, destination row stride, a two-bit prediction mode and a rounding-control flag.

The block then reads the reference rows and applies the selected filter. The filter is either a straight copy or a half-pel average: horizontal, vertical or diagonal. It writes the eight result rows through a 64-bit write port. The source address may have any byte alignment. Each source row is fetched as three consecutive aligned words, and the nine bytes needed are extracted in little-endian order.

A one-cycle done pulse marks the end of the block. The block is meant to sit beside a decoder's reference memory. The caller adds residuals and pads picture borders elsewhere.

Top module: `halfpel_pred`

## Requirements
- R1: Mode 0 (copy): output pixel (r,k) equals source byte at src_addr + r*src_stride + k, and the rnd input makes no difference to any output.
- R2: Mode 1 (horizontal): output (r,k) = (p(k,r) + p(k+1,r) + 1 - rnd) >> 1, where p(x,y) is the source byte at src_addr + y*src_stride + x.
- R3: Mode 2 (vertical): output (r,k) = (p(k,r) + p(k,r+1) + 1 - rnd) >> 1.
- R4: Mode 3 (diagonal): output (r,k) = (p(k,r) + p(k+1,r) + p(k,r+1) + p(k+1,r+1) + 2 - rnd) >> 2, with no overflow for all-255 inputs.
- R5: All four byte offsets src_addr[1:0] = 0..3 give correct results. Byte j of a memory word is bits 8j+7:8j, and it sits at byte address 4*word + j.
- R6: For each source row the block issues exactly three reads at consecutive word addresses. The first one is (src_addr + row*src_stride) >> 2. Modes 0 and 1 read 8 rows and modes 2 and 3 read 9 rows, so there are 24 or 27 reads per block and no row is read twice. rd_data is taken one cycle after rd_en.
- R7: Exactly 8 writes per block. Output row r goes to wr_addr = dst_addr + r*dst_stride, and pixel k of the row sits in wr_data bits 8k+7:8k.
- R8: done is high for exactly one cycle, the cycle after the eighth write. A start pulse during a running block is ignored.
- R9: While reset is held, and after it is released with no start, rd_en, wr_en and done stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block; taken only when idle |
| mode | input | 2 | 0 copy, 1 horizontal, 2 vertical, 3 diagonal |
| rnd | input | 1 | 0 adds the rounding term, 1 drops it |
| src_addr | input | AW | Byte address of the top-left source pixel |
| src_stride | input | SW | Source row stride in bytes, multiple of 4 |
| dst_addr | input | AW | Byte address of the first output row |
| dst_stride | input | SW | Destination row stride in bytes |
| rd_en | output | 1 | Source memory read request |
| rd_addr | output | AW-2 | Source word address |
| rd_data | input | 32 | Read data, valid one cycle after rd_en |
| wr_en | output | 1 | Output row write strobe |
| wr_addr | output | AW | Output row byte address |
| wr_data | output | 64 | Eight output pixels, pixel 0 in the low byte |
| done | output | 1 | One-cycle end-of-block pulse |

## Verification
The bench covers every byte offset, because a wrong shift amount or a big-endian merge leaves aligned blocks correct but breaks offsets 1 to 3. Each half-pel mode runs with both rounding values, since a swapped or missing rounding term is off by one on about half the pixels. An all-255 region drives the diagonal sum to its maximum, which catches an adder that is too narrow and wraps to dark pixels. Read counts and first addresses show whether the vertical modes fetch the ninth row. A start pulse in the middle of a block tests whether a second request can corrupt the block in progress.

// File: rtl/halfpel_pred.sv
module halfpel_pred #(
  parameter int AW = 16,
  parameter int SW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic          rnd,
  input  logic [AW-1:0] src_addr,
  input  logic [SW-1:0] src_stride,
  input  logic [AW-1:0] dst_addr,
  input  logic [SW-1:0] dst_stride,
  output logic          rd_en,
  output logic [AW-3:0] rd_addr,
  input  logic [31:0]   rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [63:0]   wr_data,
  output logic          done
);
  localparam int WAW = AW - 2;
  localparam int PIX = 8;
  localparam int RB  = PIX + 1;
  localparam int NW  = 3;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_WAIT, S_ROW, S_FIN} st_t;
  st_t st;

  logic [1:0]    md;
  logic          rn;
  logic [AW-1:0] rbyte;
  logic [SW-1:0] sstr, dstr;
  logic [AW-1:0] daddr;
  logic [1:0]    wi;
  logic [3:0]    srow;
  logic          pend_v;
  logic [1:0]    pend_i;
  logic [31:0]   wbuf [NW];
  logic [7:0]    prev [RB];
  logic [7:0]    cur  [RB];
  logic [63:0]   pix;
  logic [4:0]    case_idx;
  logic          last_row, emit;

  assign case_idx = {md, rn, rbyte[1:0]};
  assign rd_en    = (st == S_FETCH);
  assign rd_addr  = rbyte[AW-1:2] + WAW'(wi);
  assign last_row = (srow == (case_idx[4] ? 4'd8 : 4'd7));
  assign emit     = !(case_idx[4] && srow == 4'd0);

  logic [95:0] cat;
  logic [6:0]  boff;
  assign cat  = {wbuf[2], wbuf[1], wbuf[0]};
  assign boff = {2'b00, case_idx[1:0], 3'b000};

  for (genvar k = 0; k < RB; k++) begin : g_ext
    assign cur[k] = cat[boff + 7'(k*8) +: 8];
  end

  for (genvar k = 0; k < PIX; k++) begin : g_pix
    logic [8:0] hs, vs;
    logic [9:0] ds;
    assign hs = {1'b0, cur[k]} + {1'b0, cur[k+1]} + {8'd0, ~case_idx[2]};
    assign vs = {1'b0, prev[k]} + {1'b0, cur[k]} + {8'd0, ~case_idx[2]};
    assign ds = {2'b0, prev[k]} + {2'b0, prev[k+1]} + {2'b0, cur[k]}
              + {2'b0, cur[k+1]} + {8'd0, ~case_idx[2], case_idx[2]};
    always_comb begin
      case (case_idx[4:3])
        2'd0:    pix[k*8 +: 8] = cur[k];
        2'd1:    pix[k*8 +: 8] = hs[8:1];
        2'd2:    pix[k*8 +: 8] = vs[8:1];
        default: pix[k*8 +: 8] = ds[9:2];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_i <= '0;
    end else begin
      pend_v <= rd_en;
      pend_i <= wi;
      if (pend_v) wbuf[pend_i] <= rd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      md      <= '0;
      rn      <= 1'b0;
      rbyte   <= '0;
      sstr    <= '0;
      dstr    <= '0;
      daddr   <= '0;
      wi      <= '0;
      srow    <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      done    <= 1'b0;
      for (int i = 0; i < RB; i++) prev[i] <= '0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          md    <= mode;
          rn    <= rnd;
          rbyte <= src_addr;
          sstr  <= src_stride;
          dstr  <= dst_stride;
          daddr <= dst_addr;
          wi    <= '0;
          srow  <= '0;
          st    <= S_FETCH;
        end
        S_FETCH: begin
          if (wi == 2'd2) begin
            wi <= '0;
            st <= S_WAIT;
          end else begin
            wi <= wi + 2'd1;
          end
        end
        S_WAIT: st <= S_ROW;
        S_ROW: begin
          for (int i = 0; i < RB; i++) prev[i] <= cur[i];
          rbyte <= rbyte + AW'(sstr);
          srow  <= srow + 4'd1;
          if (emit) begin
            wr_en   <= 1'b1;
            wr_data <= pix;
            wr_addr <= daddr;
            daddr   <= daddr + AW'(dstr);
          end
          st <= last_row ? S_FIN : S_FETCH;
        end
        S_FIN: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/halfpel_pred_chk.sv
module halfpel_pred_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic [AW-3:0] rd_addr,
  input logic          wr_en,
  input logic          done
);
  logic [3:0] wcnt;
  logic [2:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= '0;
      run  <= '0;
    end else begin
      if (done) wcnt <= '0;
      else if (wr_en) wcnt <= wcnt + 4'd1;
      run <= rd_en ? ((run == 3'd7) ? run : run + 3'd1) : 3'd0;
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wr_en) && !wr_en));

  // R7
  write_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wcnt == 4'd8));

  // R6
  read_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1));

  // R6
  read_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (run < 3'd3));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_en);
endmodule

bind halfpel_pred halfpel_pred_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
  .wr_en(wr_en), .done(done)
);

// File: tb/sim_halfpel_pred.sv
module sim_halfpel_pred;
  localparam int AW = 16;
  localparam int SW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [1:0]    mode;
  logic          rnd;
  logic [AW-1:0] src_addr, dst_addr;
  logic [SW-1:0] src_stride, dst_stride;
  logic          rd_en, wr_en, done;
  logic [AW-3:0] rd_addr;
  logic [31:0]   rd_data;
  logic [AW-1:0] wr_addr;
  logic [63:0]   wr_data;

  always #10 clk = ~clk;

  halfpel_pred #(.AW(AW), .SW(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .rnd(rnd),
    .src_addr(src_addr), .src_stride(src_stride), .dst_addr(dst_addr),
    .dst_stride(dst_stride), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done)
  );

  logic [31:0] mem [256];
  always_ff @(posedge clk) rd_data <= mem[rd_addr[7:0]];

  int tests = 0, fails = 0, cyc = 0;
  int wcnt, rcnt, first_rd, last_wr_cyc;
  logic [63:0] got_d [8];
  logic [AW-1:0] got_a [8];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (wr_en) begin
      if (wcnt < 8) begin
        got_d[wcnt] = wr_data;
        got_a[wcnt] = wr_addr;
      end
      wcnt = wcnt + 1;
      last_wr_cyc = cyc;
    end
    if (rd_en) begin
      if (rcnt == 0) first_rd = int'(rd_addr);
      rcnt = rcnt + 1;
    end
  end

  always @(posedge clk) if (cyc > 150000) begin
    fails++;
    $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic int pb(int a);
    return int'(mem[(a >> 2) & 255][8*(a % 4) +: 8]);
  endfunction

  function automatic logic [7:0] expix(int m, int r, int sa, int ss, int row, int k);
    int a = sa + row*ss + k;
    case (m)
      0: return 8'(pb(a));
      1: return 8'((pb(a) + pb(a+1) + 1 - r) >> 1);
      2: return 8'((pb(a) + pb(a+ss) + 1 - r) >> 1);
      default: return 8'((pb(a) + pb(a+1) + pb(a+ss) + pb(a+ss+1) + 2 - r) >> 2);
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_blk(int m, int r, int sa, int ss, int da, int ds, string req,
                         bit mid_start = 0);
    int n;
    bit seen;
    logic [63:0] e;
    wcnt = 0; rcnt = 0; first_rd = -1; last_wr_cyc = -10;
    @(negedge clk);
    mode = 2'(m); rnd = r[0]; src_addr = AW'(sa); src_stride = SW'(ss);
    dst_addr = AW'(da); dst_stride = SW'(ds); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    for (int i = 0; i < 400 && !seen; i++) begin
      @(negedge clk);
      if (mid_start && i == 10) begin
        mode = 2'd0; rnd = 1'b1; src_addr = AW'(sa + 64); dst_addr = AW'(0);
        start = 1'b1;
      end else if (mid_start && i == 11) start = 1'b0;
      if (done) seen = 1;
    end
    chk(seen, "R8 done seen", 64'(seen), 64'd1);
    chk(cyc == last_wr_cyc + 1, "R8 done follows last write", 64'(cyc), 64'(last_wr_cyc + 1));
    @(negedge clk);
    chk(!done, "R8 done one cycle", 64'(done), 64'd0);
    chk(wcnt == 8, "R7 write count", 64'(wcnt), 64'd8);
    n = (m >= 2) ? 27 : 24;
    chk(rcnt == n, "R6 read count", 64'(rcnt), 64'(n));
    chk(first_rd == (sa >> 2), "R6 first read address", 64'(first_rd), 64'(sa >> 2));
    for (int row = 0; row < 8; row++) begin
      for (int k = 0; k < 8; k++) e[k*8 +: 8] = expix(m, r, sa, ss, row, k);
      chk(got_d[row] == e, req, got_d[row], e);
      chk(got_a[row] == AW'(da + row*ds), "R7 row address", 64'(got_a[row]), 64'(da + row*ds));
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!rd_en && !wr_en && !done, "R9 quiet after reset",
          64'({rd_en, wr_en, done}), 64'd0);
    end
  endtask

  task automatic t_copy();
    for (int o = 0; o < 4; o++) begin
      run_blk(0, 0, 100 + o, 32, 0, 8, "R1 R5 copy rnd0");
      run_blk(0, 1, 100 + o, 32, 0, 8, "R1 R5 copy rnd1");
    end
  endtask

  task automatic t_horiz();
    run_blk(1, 0, 41, 24, 512, 16, "R2 R5 horizontal rnd0");
    run_blk(1, 1, 43, 24, 512, 16, "R2 R5 horizontal rnd1");
    run_blk(1, 0, 40, 24, 512, 16, "R2 horizontal aligned");
  endtask

  task automatic t_vert();
    run_blk(2, 0, 202, 20, 64, 8, "R3 vertical rnd0");
    run_blk(2, 1, 203, 20, 64, 8, "R3 vertical rnd1");
  endtask

  task automatic t_diag();
    run_blk(3, 0, 300, 36, 128, 12, "R4 diagonal rnd0");
    run_blk(3, 1, 301, 36, 128, 12, "R4 diagonal rnd1");
    run_blk(3, 0, 307, 36, 128, 12, "R4 R5 diagonal offset 3");
  endtask

  task automatic t_sat();
    run_blk(3, 0, 803, 16, 0, 8, "R4 diagonal all-255 rnd0");
    run_blk(3, 1, 802, 16, 0, 8, "R4 diagonal all-255 rnd1");
  endtask

  task automatic t_busy();
    run_blk(3, 1, 150, 28, 256, 8, "R8 start ignored while busy", 1'b1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++)
      mem[i] = (i >= 200) ? 32'hFFFF_FFFF :
               {8'(i*7 + 3), 8'(i*13 + 200), 8'(i*29 + 17), 8'(i*53 + 91)};
    rst_n = 1'b0; start = 1'b0; mode = '0; rnd = 1'b0;
    src_addr = '0; src_stride = '0; dst_addr = '0; dst_stride = '0;
    wcnt = 0; rcnt = 0; first_rd = -1; last_wr_cyc = -10;
    repeat (3) @(negedge clk);
    chk(!rd_en && !wr_en && !done, "R9 quiet in reset", 64'({rd_en, wr_en, done}), 64'd0);
    rst_n = 1'b1;
    t_reset();
    t_copy();
    t_horiz();
    t_vert();
    t_diag();
    t_sat();
    t_busy();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule